// File: doc/BRIEF.md
# Key-Guarded Configuration Register Port

This block is a bank of 42 byte-wide configuration registers reached through a two-address window on an 8-bit I/O bus. Address 0 of the window is the index port and address 1 is the data port. The bank stays closed until software writes a two-byte entry key to the index port. Once the bank is open, an index write picks a register and the data port reads or writes that register. A separate exit key written to the index port closes the bank again.

Two kinds of guard limit data-port writes. Three fixed registers are read-only, so writes to them are dropped. A protection flag, driven by one bit of register 1, locks the low part of the bank against both reads and writes. Every register is also driven in parallel on a flat output bus, so the peripherals it configures can use the settings directly. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `cfg_port_regs`

## Requirements
- R1: After reset, registers hold 0x28 (reg 0), 0x9C (reg 1), 0x88 (reg 2), 0x78 (reg 3), 0xFF (reg 6), 0x03 (reg 13), 0x02 (reg 14), 0x80 (reg 30), 0x23 (reg 38), 0x67 (reg 39), 0x43 (reg 40) and zero elsewhere. The bank is closed, protection is off and the selected register is 0.
- R2: Two back-to-back index-port writes of 0x55 while the bank is closed open the bank.
- R3: Any other index-port value written after a first 0x55, while the bank is closed, cancels the key progress. Two further 0x55 writes are then needed.
- R4: While the bank is open, an index write below 42 selects that register and a value of 42 or more keeps the previous selection. An index-port read returns the selected register number.
- R5: While the bank is open, an index write of 0xAA closes the bank.
- R6: Data-port writes while the bank is closed change no register.
- R7: Registers 38, 39 and 41 keep their value on every data-port write.
- R8: A write to register 1 sets protection when bit 3 is 0 and clears it when bit 3 is 1. While protection is on, registers 0 to 23 can be neither written nor read, and their reads return 0xFF. Registers 24 and up stay accessible. Register 1 is then itself locked, so only reset ends protection.
- R9: Any read while the bank is closed returns 0xFF. The read data is also 0xFF whenever the read strobe is low.
- R10: Register i drives bits [8i+7:8i] of the parallel output, and a data write shows there one clock after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| cfg_regs | output | 336 | All registers, register i at bits [8i+7:8i] |

## Verification
The key logic is driven with a clean pair of 0x55 writes and with a pair broken by a foreign value. This separates a sequence detector that resets on other values from one that only counts 0x55 writes. Index values just below 42, at 42 and above, and equal to the exit key show whether the selection bound and the exit decode are separate. Data writes go to a read-only register, to a writable register below the protected limit and to one above it, both before and after protection is set. This tells a per-register write guard apart from a range guard. Reads on both ports before entry, during the open phase and after exit confirm the 0xFF masking. The parallel output is compared with the read path on the same registers.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int unsigned CFG_NREGS  = 42;
  localparam int unsigned CFG_DW     = 8;
  localparam int unsigned CFG_IDXW   = $clog2(CFG_NREGS);

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_ARMED = 2'd1,
    KEY_OPEN  = 2'd2
  } key_state_e;

  // Reset contents of the bank (R1)
  function automatic logic [7:0] cfg_reset_value(int unsigned idx);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h28;
      1:       v = 8'h9C;
      2:       v = 8'h88;
      3:       v = 8'h78;
      6:       v = 8'hFF;
      13:      v = 8'h03;
      14:      v = 8'h02;
      30:      v = 8'h80;
      38:      v = 8'h23;
      39:      v = 8'h67;
      40:      v = 8'h43;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Registers that never accept data writes (R7)
  function automatic bit cfg_is_readonly(int unsigned idx);
    return (idx == 38) || (idx == 39) || (idx == 41);
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_port_pkg::*;
#(
  parameter int unsigned NREGS     = CFG_NREGS,
  parameter int unsigned DW        = CFG_DW,
  parameter int unsigned IDXW      = CFG_IDXW,
  parameter logic [7:0]  KEY_ENTER = 8'h55,
  parameter logic [7:0]  KEY_EXIT  = 8'hAA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_wr,
  input  logic [DW-1:0]   wdata,
  output logic            cfg_open,
  output logic [IDXW-1:0] sel
);

  key_state_e      state_q, state_d;
  logic [IDXW-1:0] sel_q, sel_d;
  logic            in_range;
  logic            sel_en;

  assign in_range = (32'(wdata) < NREGS);

  always_comb begin
    state_d = state_q;
    sel_en  = 1'b0;
    if (idx_wr) begin
      case (state_q)
        KEY_IDLE:  if (wdata == DW'(KEY_ENTER)) state_d = KEY_ARMED;
        KEY_ARMED: state_d = (wdata == DW'(KEY_ENTER)) ? KEY_OPEN : KEY_IDLE;
        KEY_OPEN: begin
          sel_en = in_range;
          if (wdata == DW'(KEY_EXIT)) state_d = KEY_IDLE;
        end
        default:   state_d = KEY_IDLE;
      endcase
    end
    sel_d = sel_en ? wdata[IDXW-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  assign cfg_open = (state_q == KEY_OPEN);
  assign sel      = sel_q;

  AST_KEY_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_ARMED && idx_wr && wdata == DW'(KEY_ENTER)) |=> cfg_open); // R2
  AST_KEY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && idx_wr && wdata != DW'(KEY_ENTER)) |=> (state_q == KEY_IDLE)); // R3
  AST_KEY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == DW'(KEY_EXIT)) |=> !cfg_open); // R5
  AST_SEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel) < NREGS); // R4
  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !in_range) |=> $stable(sel)); // R4

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int unsigned NREGS      = CFG_NREGS,
  parameter int unsigned DW         = CFG_DW,
  parameter int unsigned IDXW       = CFG_IDXW,
  parameter int unsigned PROT_LIMIT = 24,
  parameter int unsigned PROT_REG   = 1,
  parameter int unsigned PROT_BIT   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic               cfg_open,
  input  logic [IDXW-1:0]    sel,
  input  logic [DW-1:0]      wdata,
  output logic [NREGS*DW-1:0] regs_flat,
  output logic               prot
);

  logic sel_low;
  logic wr_ok;
  logic prot_q, prot_d, prot_en;

  assign sel_low = (32'(sel) < PROT_LIMIT);
  assign wr_ok   = data_wr && cfg_open && !(prot_q && sel_low);

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    if (cfg_is_readonly(gi)) begin : g_ro
      assign regs_flat[gi*DW +: DW] = DW'(cfg_reset_value(gi));
    end else begin : g_rw
      logic [DW-1:0] q, d;
      logic          en;
      assign en = wr_ok && (32'(sel) == gi);
      always_comb begin
        d = en ? wdata : q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= DW'(cfg_reset_value(gi));
        end else begin
          q <= d;
        end
      end
      assign regs_flat[gi*DW +: DW] = q;
    end
  end

  assign prot_en = wr_ok && (32'(sel) == PROT_REG);

  always_comb begin
    prot_d = prot_en ? ~wdata[PROT_BIT] : prot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
    end
  end

  assign prot = prot_q;

  AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(regs_flat)); // R6
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cfg_open && cfg_is_readonly(32'(sel))) |=> $stable(regs_flat)); // R7
  AST_PROT_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && data_wr && sel_low) |=> $stable(regs_flat)); // R8
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prot_q |=> prot_q); // R8

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_port_pkg::*;
#(
  parameter int unsigned NREGS      = CFG_NREGS,
  parameter int unsigned DW         = CFG_DW,
  parameter int unsigned IDXW       = CFG_IDXW,
  parameter int unsigned PROT_LIMIT = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  logic                addr,
  input  logic                cfg_open,
  input  logic                prot,
  input  logic [IDXW-1:0]     sel,
  input  logic [NREGS*DW-1:0] regs_flat,
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] picked;
  logic          hidden;

  always_comb begin
    picked = '1;
    for (int i = 0; i < NREGS; i++) begin
      if (32'(sel) == i) picked = regs_flat[i*DW +: DW];
    end
  end

  assign hidden = prot && (32'(sel) < PROT_LIMIT);

  always_comb begin
    rdata = '1;
    if (rd && cfg_open) begin
      if (!addr)       rdata = DW'(sel);
      else if (!hidden) rdata = picked;
    end
  end

  AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cfg_open) |-> (rdata == '1)); // R9
  AST_HIDDEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr && prot && 32'(sel) < PROT_LIMIT) |-> (rdata == '1)); // R8

endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int unsigned NREGS      = CFG_NREGS,
  parameter int unsigned DW         = CFG_DW,
  parameter int unsigned PROT_LIMIT = 24,
  parameter int unsigned PROT_REG   = 1,
  parameter int unsigned PROT_BIT   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  output logic [NREGS*DW-1:0] cfg_regs
);

  localparam int unsigned IDXW = $clog2(NREGS);

  logic            rst_i_n;
  logic            idx_wr, data_wr;
  logic            cfg_open, prot;
  logic [IDXW-1:0] sel;
  logic [DW-1:0]   rdata_w;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr &&  bus_addr;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfg_key_ctrl #(
    .NREGS(NREGS), .DW(DW), .IDXW(IDXW)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .cfg_open (cfg_open),
    .sel      (sel)
  );

  cfg_reg_bank #(
    .NREGS(NREGS), .DW(DW), .IDXW(IDXW),
    .PROT_LIMIT(PROT_LIMIT), .PROT_REG(PROT_REG), .PROT_BIT(PROT_BIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .data_wr   (data_wr),
    .cfg_open  (cfg_open),
    .sel       (sel),
    .wdata     (bus_wdata),
    .regs_flat (cfg_regs),
    .prot      (prot)
  );

  cfg_read_mux #(
    .NREGS(NREGS), .DW(DW), .IDXW(IDXW), .PROT_LIMIT(PROT_LIMIT)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .cfg_open  (cfg_open),
    .prot      (prot),
    .sel       (sel),
    .regs_flat (cfg_regs),
    .rdata     (rdata_w)
  );

  assign bus_rdata = rdata_w;

endmodule

// File: tb/sim_cfg_port_regs.sv
module sim_cfg_port_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 42;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_addr;
  logic [7:0]        bus_wdata;
  logic              bus_wr;
  logic              bus_rd;
  logic [7:0]        bus_rdata;
  logic [NREGS*8-1:0] cfg_regs;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_regs u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cfg_regs  (cfg_regs)
  );

  // Monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL %s read without expectation: got %02h expected none", "R9", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (bus_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s read: got %02h expected %02h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] v);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_reg(input int idx, input logic [7:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (cfg_regs[idx*8 +: 8] !== exp) begin
      errors++;
      $display("FAIL %s reg %0d: got %02h expected %02h", tag, idx, cfg_regs[idx*8 +: 8], exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bus_addr = 1'b0; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    do_reset();

    // R1 / R10: reset contents on the parallel output
    chk_reg(0,  8'h28, "R1");
    chk_reg(1,  8'h9C, "R1");
    chk_reg(6,  8'hFF, "R1");
    chk_reg(5,  8'h00, "R1");
    chk_reg(39, 8'h67, "R10");
    chk_reg(40, 8'h43, "R1");
    // R9: closed bank reads 0xFF on both ports, and with no strobe
    rd(1'b1, 8'hFF, "R9");
    rd(1'b0, 8'hFF, "R9");
    // R6: data write while closed is dropped
    wr(1'b1, 8'h12);
    chk_reg(0, 8'h28, "R6");
    // R3: broken key does not open
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h11);
    wr(1'b0, 8'h55);
    rd(1'b0, 8'hFF, "R3");
    // R2: second consecutive 0x55 opens, selection is 0 after reset (R1)
    wr(1'b0, 8'h55);
    rd(1'b0, 8'h00, "R2");
    rd(1'b1, 8'h28, "R2");
    // R4: selection range
    wr(1'b0, 8'h05);
    rd(1'b0, 8'h05, "R4");
    wr(1'b0, 8'h2A);
    rd(1'b0, 8'h05, "R4");
    wr(1'b0, 8'h29);
    rd(1'b0, 8'h29, "R4");
    // R7: read-only registers
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h00, "R7");
    wr(1'b0, 8'h26);
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h23, "R7");
    wr(1'b0, 8'h27);
    wr(1'b1, 8'hF0);
    chk_reg(39, 8'h67, "R7");
    // R10: writable register visible on parallel output
    wr(1'b0, 8'h28);
    wr(1'b1, 8'h9A);
    chk_reg(40, 8'h9A, "R10");
    rd(1'b1, 8'h9A, "R10");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h11);
    rd(1'b1, 8'h11, "R10");
    // R8: protection with bit 3 of reg 1 written 0
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h94);
    chk_reg(1, 8'h94, "R8");
    rd(1'b1, 8'hFF, "R8");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h77);
    chk_reg(2, 8'h11, "R8");
    rd(1'b1, 8'hFF, "R8");
    wr(1'b0, 8'h18);
    wr(1'b1, 8'h3C);
    rd(1'b1, 8'h3C, "R8");
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h9C);
    chk_reg(1, 8'h94, "R8");
    rd(1'b1, 8'hFF, "R8");
    // R5: exit key closes the bank
    wr(1'b0, 8'hAA);
    rd(1'b0, 8'hFF, "R5");
    rd(1'b1, 8'hFF, "R5");
    wr(1'b1, 8'h00);
    chk_reg(1, 8'h94, "R6");
    // R1: reset clears protection and restores defaults
    do_reset();
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h01);
    rd(1'b1, 8'h9C, "R1");
    chk_reg(2, 8'h88, "R1");
    chk_reg(24, 8'h00, "R1");

    repeat (3) @(posedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9 scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule